// File: doc/BRIEF.md
# BERT Pattern Generator with Zero Suppression

This block produces the transmit side of a bit error rate test: a serial bit stream carrying a known pattern that a receiver compares against its own copy. It has two pattern sources. A 32-bit rotating word repeats a user-programmed pattern. A 20-stage linear feedback shift register produces a pseudorandom sequence from a programmed seed. A byte-wide write port fills four pattern bytes and one control byte. The control byte selects the source and enables zero suppression. When zero suppression is on, the block emits a one in place of any bit that would start a run of fifteen zeros.

The generator loads new contents only on a rising edge of a load level. That level is the OR of a control-register bit and an external pin. If either source stays high, no further load follows, even when the other source is toggled. To load again, both must drop low and one must rise again.

Bits leave through a valid/ready stream. `tx_valid` is low during reset and high afterwards. A bit counts as taken on each clock in which both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, the generator holds its position, and `tx_bit` stays unchanged as long as the control byte is not rewritten. The consumer may stall for any number of cycles.

Top module: `bert_pattern_gen`

## Requirements
- R1: A synchronous reset clears the control byte and the pattern bytes, clears the rotating word, and sets the shift register to 20'h00001. `tx_valid` is 0 while reset is held and 1 from the first clock after it is released.
- R2: The write port uses these addresses:
  - Address 0 sets the control byte: bit 0 is the load bit, bit 1 selects the source (0 = repetitive, 1 = pseudorandom), and bit 2 enables zero suppression.
  - Addresses 4, 5, 6 and 7 set pattern bits 7:0, 15:8, 23:16 and 31:24.
  - Writes to addresses 1 to 3 have no effect.
- R3: On a clock where the OR of the load bit and `load_pin` is 1, having been 0 on the clock before, the generator takes the pattern: the rotating word becomes all 32 pattern bits and the shift register becomes pattern bits 19:0. The new contents appear on `tx_bit` in the following cycle.
- R4: While the load level stays high, no further load happens, even if the other source rises or the pattern bytes change. A new load needs the level to fall and rise again.
- R5: In repetitive mode, `tx_bit` is bit 0 of the rotating word. Each taken bit rotates the word right by one, so the pattern goes out least significant bit first.
- R6: In pseudorandom mode, `tx_bit` is bit 0 of the shift register s. Each taken bit replaces s with {s[0]^s[3], s[19:1]}, which is the x^20+x^17+1 generator run as a right shift.
- R7: A load whose bits 19:0 are all zero sets the shift register to 20'h00001, so the register never holds zero.
- R8: With zero suppression on, `tx_bit` is forced to 1 whenever bits 14:1 of the active source (the rotating word or the shift register) are all 0.
- R9: On a clock with no load and no taken bit, neither the rotating word nor the shift register changes.
- R10: When a load edge and a taken bit fall on the same clock, the load wins. The first loaded bit is presented next, not skipped.
- R11: Only the selected source advances on a taken bit. The other source keeps its position across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Write data |
| load_pin | input | 1 | External load request, ORed with the control load bit |
| tx_valid | output | 1 | Stream valid, high whenever out of reset |
| tx_ready | input | 1 | Consumer takes the current bit and advances the generator |
| tx_bit | output | 1 | Current pattern bit |

## Verification
The bench builds the block with its default parameters: a 32-bit pattern, a 20-stage register with its second tap at bit 3, a 14-bit lookahead and a reset seed of 1. At this size a seed with a single high bit above the lookahead window reaches suppression at once, and a long pseudorandom run passes through the register's natural runs of up to nineteen zeros. The same defaults let the bench mix stalls, mode changes, held load levels and loads on the same clock as a taken bit, so every edge-detection and priority case shows up within a few thousand cycles.

// File: rtl/bert_gen_pkg.sv
package bert_gen_pkg;
  localparam int ADDR_W    = 3;
  localparam int CTRL_ADDR = 0;
  localparam int PAT_BASE  = 4;

  typedef enum logic {
    SRC_REPEAT = 1'b0,
    SRC_PRBS   = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic     zs_en;
    src_sel_e src;
    logic     ld;
  } ctrl_t;
endpackage

// File: rtl/bert_cfg_regs.sv
module bert_cfg_regs
  import bert_gen_pkg::*;
#(
  parameter int PAT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output ctrl_t               ctrl,
  output logic [PAT_W-1:0]    pat_word
);
  localparam int NLANE = PAT_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == CTRL_A) ctrl_q <= ctrl_t'(wr_data[2:0]);
  end
  assign ctrl = ctrl_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(PAT_BASE + g);
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else if (wr_en && wr_addr == LANE_A) lane_q <= wr_data;
    end
    assign pat_word[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/bert_load_edge.sv
module bert_load_edge (
  input  logic clk,
  input  logic rst,
  input  logic reg_ld,
  input  logic pin_ld,
  output logic fire
);
  logic lvl, prev_q;

  assign lvl  = reg_ld | pin_ld;
  assign fire = lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  // R4: a held level gives one load, never two in a row
  p_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/bert_pattern_core.sv
module bert_pattern_core
  import bert_gen_pkg::*;
#(
  parameter int PAT_W    = 32,
  parameter int LFSR_W   = 20,
  parameter int LFSR_TAP = 3,
  parameter int ZS_LEN   = 14,
  parameter logic [LFSR_W-1:0] RST_SEED = LFSR_W'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAT_W-1:0] pat_word,
  input  src_sel_e         src,
  input  logic             zs_en,
  input  logic             adv,
  output logic             bit_o
);
  logic [PAT_W-1:0]  rep_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] seed_raw, seed_ok;
  logic              fb, raw_bit, ahead_zero;

  assign seed_raw = pat_word[LFSR_W-1:0];
  assign seed_ok  = (seed_raw == '0) ? LFSR_W'(1) : seed_raw;
  assign fb       = lfsr_q[0] ^ lfsr_q[LFSR_TAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q  <= '0;
      lfsr_q <= RST_SEED;
    end else if (load) begin
      rep_q  <= pat_word;
      lfsr_q <= seed_ok;
    end else if (adv) begin
      if (src == SRC_PRBS) lfsr_q <= {fb, lfsr_q[LFSR_W-1:1]};
      else                 rep_q  <= {rep_q[0], rep_q[PAT_W-1:1]};
    end
  end

  always_comb begin
    if (src == SRC_PRBS) begin
      raw_bit    = lfsr_q[0];
      ahead_zero = ~|lfsr_q[ZS_LEN:1];
    end else begin
      raw_bit    = rep_q[0];
      ahead_zero = ~|rep_q[ZS_LEN:1];
    end
  end

  assign bit_o = raw_bit | (zs_en & ahead_zero);

  p_seed_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  p_load_copy_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> rep_q == $past(pat_word));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(rep_q) && $stable(lfsr_q)));
  p_other_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && src == SRC_PRBS) |=> $stable(rep_q));
endmodule

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_gen_pkg::*;
#(
  parameter int PAT_W    = 32,
  parameter int LFSR_W   = 20,
  parameter int LFSR_TAP = 3,
  parameter int ZS_LEN   = 14,
  parameter logic [LFSR_W-1:0] RST_SEED = LFSR_W'(1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr_en,
  input  logic [2:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        load_pin,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_bit
);
  ctrl_t            ctrl;
  logic [PAT_W-1:0] pat_word;
  logic             load_fire, take, valid_q;

  bert_cfg_regs #(.PAT_W(PAT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .ctrl(ctrl), .pat_word(pat_word)
  );

  bert_load_edge u_edge (
    .clk(clk), .rst(rst), .reg_ld(ctrl.ld), .pin_ld(load_pin), .fire(load_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= 1'b1;
  end
  assign tx_valid = valid_q;
  assign take     = valid_q & tx_ready;

  bert_pattern_core #(
    .PAT_W(PAT_W), .LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP),
    .ZS_LEN(ZS_LEN), .RST_SEED(RST_SEED)
  ) u_core (
    .clk(clk), .rst(rst), .load(load_fire), .pat_word(pat_word),
    .src(ctrl.src), .zs_en(ctrl.zs_en), .adv(take), .bit_o(tx_bit)
  );

  // R1: the stream is never offered in the first cycle of reset release edge
  p_valid_reset_r1: assert property (@(posedge clk)
    rst |=> !tx_valid);
endmodule

// File: tb/tb_bert_pattern_gen.sv
module tb_bert_pattern_gen;
  localparam int CLK_P = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       cfg_wr_en = 0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       load_pin = 0;
  logic       tx_ready = 0;
  logic       tx_valid, tx_bit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_rep, pat_sh;
  logic [19:0] m_lfsr;
  logic [7:0]  ctrl_sh;

  always #(CLK_P/2) clk = ~clk;

  bert_pattern_gen dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .load_pin(load_pin), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit)
  );

  function automatic logic exp_bit(input logic [31:0] r, input logic [19:0] s,
                                   input logic [7:0] c);
    logic [31:0] v;
    v = c[1] ? {12'd0, s} : r;
    return v[0] | (c[2] & (v[14:1] == 14'd0));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_adv();
    if (ctrl_sh[1]) m_lfsr = {m_lfsr[0] ^ m_lfsr[3], m_lfsr[19:1]};
    else            m_rep  = {m_rep[0], m_rep[31:1]};
  endtask

  task automatic model_load();
    m_rep  = pat_sh;
    m_lfsr = (pat_sh[19:0] == 20'd0) ? 20'd1 : pat_sh[19:0];
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic set_pat(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), w[i*8 +: 8]);
    pat_sh = w;
  endtask

  task automatic set_mode(input logic prbs, input logic zs);
    ctrl_sh = {5'd0, zs, prbs, 1'b0};
    wr(3'd0, ctrl_sh);
  endtask

  task automatic load_by_reg();
    wr(3'd0, ctrl_sh | 8'h01);
    @(negedge clk);
    model_load();
    wr(3'd0, ctrl_sh);
  endtask

  task automatic load_by_pin();
    @(negedge clk); load_pin = 1;
    @(negedge clk); model_load(); load_pin = 0;
  endtask

  task automatic stream(input int n, input string req);
    logic last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (last) model_adv();
      chk(req, tx_bit, exp_bit(m_rep, m_lfsr, ctrl_sh));
      last = ($urandom % 10) < 7;
      tx_ready = last;
    end
    @(negedge clk);
    if (last) model_adv();
    tx_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_rep = 0; m_lfsr = 20'd1; pat_sh = 0; ctrl_sh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", tx_valid, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 valid after reset", tx_valid, 1'b1);
    chk("R1 cleared word", tx_bit, 1'b0);
    set_mode(1'b1, 1'b0);
    chk("R1 reset seed", tx_bit, 1'b1);
    stream(40, "R1 R6 from reset seed");

    // R2 R3 R5: repetitive pattern loaded through the register bit
    set_mode(1'b0, 1'b0);
    set_pat(32'hA5C3_0F96);
    load_by_reg();
    stream(80, "R5 repeat via reg load");
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    stream(20, "R2 ignored addresses");

    // R4: held pin blocks reload from register bit and new pattern
    set_pat(32'h1357_9BDF);
    @(negedge clk); load_pin = 1;
    @(negedge clk); model_load();
    set_pat(32'hFFFF_0000);
    wr(3'd0, ctrl_sh | 8'h01);
    @(negedge clk);
    stream(40, "R4 no reload while high");
    wr(3'd0, ctrl_sh);
    load_pin = 0;
    @(negedge clk);
    load_by_pin();
    stream(40, "R4 reload after fall");

    // R10: load and take on the same clock
    set_pat(32'h0000_0001);
    @(negedge clk); load_pin = 1; tx_ready = 1;
    @(negedge clk); model_load(); load_pin = 0; tx_ready = 0;
    chk("R10 first bit kept", tx_bit, 1'b1);
    stream(33, "R10 after priority load");

    // R6 pseudorandom sequence
    set_mode(1'b1, 1'b0);
    set_pat(32'h000A_BCDE);
    load_by_reg();
    stream(300, "R6 prbs");

    // R7 zero seed replaced
    set_pat(32'h1230_0000);
    load_by_pin();
    chk("R7 zero seed", tx_bit, 1'b1);
    stream(60, "R7 after zero seed");

    // R8 zero suppression
    set_pat(32'h0001_0000);
    load_by_reg();
    chk("R8 unsuppressed zero", tx_bit, 1'b0);
    set_mode(1'b1, 1'b1);
    chk("R8 forced one", tx_bit, 1'b1);
    stream(400, "R8 zs prbs");

    // R11: mode switches keep the idle source in place
    set_mode(1'b0, 1'b0);
    set_pat(32'hC0FF_EE11);
    load_by_reg();
    stream(25, "R11 repeat part 1");
    set_mode(1'b1, 1'b0);
    stream(25, "R11 prbs part");
    set_mode(1'b0, 1'b0);
    stream(25, "R11 repeat part 2");

    // random episodes, R9 stalls inside every stream
    for (int e = 0; e < 25; e++) begin
      logic pm, zs;
      pm = 1'($urandom % 2);
      zs = pm ? 1'($urandom % 2) : 1'b0;
      set_mode(pm, zs);
      set_pat($urandom);
      if ($urandom % 2) load_by_reg(); else load_by_pin();
      stream(40 + int'($urandom % 80), "R9 random episode");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule